// File: doc/BRIEF.md
# Calendar Timekeeping Core

This block is the counting heart of a real-time clock. It holds seconds, minutes, hours, day of week, date, month and a two-digit year, together with alarm bytes for seconds, minutes and hours. A one-cycle pulse on `tick_1hz` advances the stored time by one second. Each advance handles every rollover, from seconds through to the year, including month lengths and leap years. After each advance the new time is compared with the alarm bytes. When all three match, a sticky alarm flag is set.

Every stored byte can be kept in BCD or in plain binary. Hours can run on a 24-hour clock or on a 12-hour clock with a PM bit. A host reaches the block through a synchronous register port. To load the time, the host sets a hold bit, writes the time and calendar bytes, and then clears the hold bit. Reads come from a shadow copy of the working counters, so a read never returns a half-updated value.

Top module: `rtc_calendar_core`

## Requirements
- R1: The register addresses are: 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 day of week, 7 date, 8 month, 9 year, 10 control, 11 status, and any other address reads 0. Control bit 0 is the hold bit, bit 1 selects binary (1) or BCD (0), and bit 2 selects 24-hour (1) or 12-hour (0). After reset the registers read as follows: time 00:00:00, day 1, date 1, month 1, year 0, all alarm bytes 0xFF, control 0x04 and status 0x00.
- R2: Each accepted tick adds one second. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Without a tick or a write, the time bytes hold their values.
- R3: In 24-hour mode, hours count 0 to 23. In 12-hour mode, bit 7 of the hours byte is 1 for PM and the lower bits hold 1 to 12. The sequence runs 12 AM, 1 AM … 11 AM, 12 PM, 1 PM … 11 PM, then 12 AM. The calendar carries on the step to midnight.
- R4: Day of week counts 1 to 7 and steps only at midnight, wrapping from 7 to 1.
- R5: The date wraps to 1 after the last day of the month. April, June, September and November have 30 days and February has 28. February has 29 when the year is divisible by 4, and year 00 counts as a leap year. Month 12 wraps to 1 and carries into the year. Year 99 wraps to 00.
- R6: While the hold bit is 1, ticks are dropped and writes to the time and calendar bytes load the working counters. After the hold bit is cleared, the next tick counts on from the written values.
- R7: While the hold bit is 0, writes to the time and calendar bytes have no effect. The alarm bytes and the control register can be written at any time.
- R8: All counting uses the encoding chosen by control bit 1. For example, seconds 09 become 0x10 in BCD and 0x0A in binary. Writing the mode bit does not convert bytes that are already stored.
- R9: The alarm flag (status bit 0) is set on any advance after which seconds, minutes and hours each equal their alarm bytes. It is not set otherwise.
- R10: A read of the status address clears the alarm flag. If the flag is set in the same cycle as the clearing read, setting takes priority.
- R11: A time value changed at a clock edge becomes readable one clock later. In the cycle between, reads return the complete previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| host_we | input | 1 | Register write strobe |
| host_re | input | 1 | Register read strobe (clears status on address 11) |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` |

## Verification
A wrong carry in the counting chain appears at the ports on the first tick that crosses a boundary. Examples are a month end, a noon or midnight step in 12-hour form, a BCD nibble wrap, or a year wrap. The corrupt byte is readable one clock after that tick. The sweeps therefore place the counters one second before every such boundary, over every month and every two-digit year, in both encodings and both hour forms. A bad hold or alarm path shows up as a byte that changes, or a status bit that is wrong, on the very next read.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int DW = 8;
    localparam int AW = 4;

    localparam logic [AW-1:0] ADDR_SEC     = 4'd0;
    localparam logic [AW-1:0] ADDR_SEC_AL  = 4'd1;
    localparam logic [AW-1:0] ADDR_MIN     = 4'd2;
    localparam logic [AW-1:0] ADDR_MIN_AL  = 4'd3;
    localparam logic [AW-1:0] ADDR_HOUR    = 4'd4;
    localparam logic [AW-1:0] ADDR_HOUR_AL = 4'd5;
    localparam logic [AW-1:0] ADDR_DOW     = 4'd6;
    localparam logic [AW-1:0] ADDR_DATE    = 4'd7;
    localparam logic [AW-1:0] ADDR_MONTH   = 4'd8;
    localparam logic [AW-1:0] ADDR_YEAR    = 4'd9;
    localparam logic [AW-1:0] ADDR_CTRL    = 4'd10;
    localparam logic [AW-1:0] ADDR_STAT    = 4'd11;

    typedef struct packed {
        logic [DW-1:0] sec;
        logic [DW-1:0] min;
        logic [DW-1:0] hour;
        logic [DW-1:0] dow;
        logic [DW-1:0] date;
        logic [DW-1:0] month;
        logic [DW-1:0] year;
    } rtc_time_t;

    typedef struct packed {
        logic h24;
        logic bin;
        logic hold;
    } rtc_ctrl_t;

    localparam rtc_time_t TIME_RST = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                       dow: 8'h01, date: 8'h01, month: 8'h01,
                                       year: 8'h00};
    localparam rtc_ctrl_t CTRL_RST = '{h24: 1'b1, bin: 1'b0, hold: 1'b0};
    localparam logic [DW-1:0] ALARM_RST = 8'hFF;

    function automatic logic is_time_addr(input logic [AW-1:0] a);
        return (a == ADDR_SEC) || (a == ADDR_MIN) || (a == ADDR_HOUR) ||
               (a == ADDR_DOW) || (a == ADDR_DATE) || (a == ADDR_MONTH) ||
               (a == ADDR_YEAR);
    endfunction

    // stored byte -> binary value
    function automatic logic [DW-1:0] dec_byte(input logic [DW-1:0] v, input logic bin);
        return bin ? v : (8'(v[7:4]) * 8'd10 + 8'(v[3:0]));
    endfunction

    // binary value (< 100) -> stored byte
    function automatic logic [DW-1:0] enc_byte(input logic [DW-1:0] b, input logic bin);
        return bin ? b : (((b / 8'd10) << 4) | (b % 8'd10));
    endfunction

    // stored hours byte -> 0..23
    function automatic logic [DW-1:0] hour_to24(input logic [DW-1:0] v,
                                                input logic bin, input logic h24);
        logic [DW-1:0] h;
        if (h24) return dec_byte(v, bin);
        h = dec_byte({1'b0, v[6:0]}, bin);
        if (h == 8'd12) h = 8'd0;
        return v[7] ? (h + 8'd12) : h;
    endfunction

    // 0..23 -> stored hours byte
    function automatic logic [DW-1:0] hour_from24(input logic [DW-1:0] h,
                                                  input logic bin, input logic h24);
        logic [DW-1:0] h12;
        if (h24) return enc_byte(h, bin);
        h12 = (h >= 8'd12) ? (h - 8'd12) : h;
        if (h12 == 8'd0) h12 = 8'd12;
        return {(h >= 8'd12), 7'(enc_byte(h12, bin))};
    endfunction

    function automatic logic [DW-1:0] month_len(input logic [DW-1:0] m, input logic [DW-1:0] y);
        case (m)
            8'd2:                     return ((y % 8'd4) == 8'd0) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:  return 8'd30;
            default:                  return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    input  logic      bin,
    input  logic      h24,
    output rtc_time_t nxt
);
    localparam logic [DW-1:0] SEC_TOP  = 8'd59;
    localparam logic [DW-1:0] MIN_TOP  = 8'd59;
    localparam logic [DW-1:0] HOUR_TOP = 8'd23;
    localparam logic [DW-1:0] DOW_TOP  = 8'd7;
    localparam logic [DW-1:0] MON_TOP  = 8'd12;
    localparam logic [DW-1:0] YEAR_TOP = 8'd99;

    logic [DW-1:0] s, m, h, d, dt, mo, y, mlen;
    logic          c_min, c_hr, c_day, c_mon, c_yr;

    always_comb begin
        s    = dec_byte(cur.sec, bin);
        m    = dec_byte(cur.min, bin);
        h    = hour_to24(cur.hour, bin, h24);
        d    = dec_byte(cur.dow, bin);
        dt   = dec_byte(cur.date, bin);
        mo   = dec_byte(cur.month, bin);
        y    = dec_byte(cur.year, bin);
        mlen = month_len(mo, y);

        c_min = (s >= SEC_TOP);
        c_hr  = c_min && (m >= MIN_TOP);
        c_day = c_hr && (h >= HOUR_TOP);
        c_mon = c_day && (dt >= mlen);
        c_yr  = c_mon && (mo >= MON_TOP);

        nxt.sec   = enc_byte(c_min ? 8'd0 : s + 8'd1, bin);
        nxt.min   = c_min ? enc_byte(c_hr ? 8'd0 : m + 8'd1, bin) : cur.min;
        nxt.hour  = c_hr  ? hour_from24(c_day ? 8'd0 : h + 8'd1, bin, h24) : cur.hour;
        nxt.dow   = c_day ? enc_byte((d >= DOW_TOP) ? 8'd1 : d + 8'd1, bin) : cur.dow;
        nxt.date  = c_day ? enc_byte(c_mon ? 8'd1 : dt + 8'd1, bin) : cur.date;
        nxt.month = c_mon ? enc_byte(c_yr ? 8'd1 : mo + 8'd1, bin) : cur.month;
        nxt.year  = c_yr  ? enc_byte((y >= YEAR_TOP) ? 8'd0 : y + 8'd1, bin) : cur.year;
    end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic [DW-1:0] new_sec,
    input  logic [DW-1:0] new_min,
    input  logic [DW-1:0] new_hour,
    input  logic [DW-1:0] al_sec,
    input  logic [DW-1:0] al_min,
    input  logic [DW-1:0] al_hour,
    input  logic          clr,
    output logic          flag
);
    logic hit;

    assign hit = adv && (new_sec == al_sec) && (new_min == al_min) && (new_hour == al_hour);

    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag); // R9
    AST_FLAG_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (!hit && !flag) |=> !flag); // R9
    AST_FLAG_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !flag); // R10
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_1hz,
    input  logic          host_we,
    input  logic          host_re,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata
);
    rtc_time_t     work, shadow, nxt;
    rtc_ctrl_t     ctrl;
    logic [DW-1:0] al_sec, al_min, al_hour;
    logic          adv, time_wr, stat_clr, alarm_flag;

    assign adv      = tick_1hz && !ctrl.hold;
    assign time_wr  = host_we && ctrl.hold && is_time_addr(host_addr);
    assign stat_clr = host_re && (host_addr == ADDR_STAT);

    rtc_advance u_adv (
        .cur (work),
        .bin (ctrl.bin),
        .h24 (ctrl.h24),
        .nxt (nxt)
    );

    rtc_alarm u_alarm (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .new_sec  (nxt.sec),
        .new_min  (nxt.min),
        .new_hour (nxt.hour),
        .al_sec   (al_sec),
        .al_min   (al_min),
        .al_hour  (al_hour),
        .clr      (stat_clr),
        .flag     (alarm_flag)
    );

    // working counters
    always_ff @(posedge clk) begin
        if (rst) begin
            work <= TIME_RST;
        end else if (adv) begin
            work <= nxt;
        end else if (time_wr) begin
            case (host_addr)
                ADDR_SEC:   work.sec   <= host_wdata;
                ADDR_MIN:   work.min   <= host_wdata;
                ADDR_HOUR:  work.hour  <= host_wdata;
                ADDR_DOW:   work.dow   <= host_wdata;
                ADDR_DATE:  work.date  <= host_wdata;
                ADDR_MONTH: work.month <= host_wdata;
                ADDR_YEAR:  work.year  <= host_wdata;
                default: ;
            endcase
        end
    end

    // read-side copy, refreshed one clock behind the counters
    always_ff @(posedge clk) begin
        if (rst) shadow <= TIME_RST;
        else     shadow <= work;
    end

    // control and alarm bytes
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= CTRL_RST;
            al_sec  <= ALARM_RST;
            al_min  <= ALARM_RST;
            al_hour <= ALARM_RST;
        end else if (host_we) begin
            case (host_addr)
                ADDR_CTRL:    ctrl    <= rtc_ctrl_t'(host_wdata[2:0]);
                ADDR_SEC_AL:  al_sec  <= host_wdata;
                ADDR_MIN_AL:  al_min  <= host_wdata;
                ADDR_HOUR_AL: al_hour <= host_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (host_addr)
            ADDR_SEC:     host_rdata = shadow.sec;
            ADDR_SEC_AL:  host_rdata = al_sec;
            ADDR_MIN:     host_rdata = shadow.min;
            ADDR_MIN_AL:  host_rdata = al_min;
            ADDR_HOUR:    host_rdata = shadow.hour;
            ADDR_HOUR_AL: host_rdata = al_hour;
            ADDR_DOW:     host_rdata = shadow.dow;
            ADDR_DATE:    host_rdata = shadow.date;
            ADDR_MONTH:   host_rdata = shadow.month;
            ADDR_YEAR:    host_rdata = shadow.year;
            ADDR_CTRL:    host_rdata = {5'b0, ctrl};
            ADDR_STAT:    host_rdata = {7'b0, alarm_flag};
            default:      host_rdata = '0;
        endcase
    end

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick_1hz && !host_we) |=> $stable(work)); // R2
    AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv && !host_we && (dec_byte(work.sec, ctrl.bin) < 8'd59))
        |=> (dec_byte(work.sec, ctrl.bin) == $past(dec_byte(work.sec, ctrl.bin)) + 8'd1)); // R2
    AST_SET_DROPS_TICK: assert property (@(posedge clk) disable iff (rst)
        (ctrl.hold && !host_we) |=> $stable(work)); // R6
    AST_TIME_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.hold && !tick_1hz && host_we && is_time_addr(host_addr)) |=> $stable(work)); // R7
endmodule

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       we = 1'b0;
    logic       re = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    rtc_calendar_core dut (
        .clk(clk), .rst(rst), .tick_1hz(tick), .host_we(we), .host_re(re),
        .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata)
    );

    function automatic logic [7:0] enc(int v, bit bin);
        return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] enc_hr(int h, bit bin, bit h24);
        int h12;
        if (h24) return enc(h, bin);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return (h >= 12 ? 8'h80 : 8'h00) | enc(h12, bin);
    endfunction

    function automatic int mlen(int m, int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; re = 1'b1; #1 d = rdata;
        @(negedge clk); re = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [3:0] a, logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic tick1();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic ctrl_wr(bit hold, bit bin, bit h24);
        wr(4'd10, {5'b0, h24, bin, hold});
    endtask

    task automatic load(bit bin, bit h24, int s, int m, int h, int dw, int dt, int mo, int y);
        ctrl_wr(1'b1, bin, h24);
        wr(4'd0, enc(s, bin));
        wr(4'd2, enc(m, bin));
        wr(4'd4, enc_hr(h, bin, h24));
        wr(4'd6, enc(dw, bin));
        wr(4'd7, enc(dt, bin));
        wr(4'd8, enc(mo, bin));
        wr(4'd9, enc(y, bin));
        ctrl_wr(1'b0, bin, h24);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values and map
        rd_chk("R1 sec", 4'd0, 8'h00);   rd_chk("R1 sec_al", 4'd1, 8'hFF);
        rd_chk("R1 min", 4'd2, 8'h00);   rd_chk("R1 min_al", 4'd3, 8'hFF);
        rd_chk("R1 hour", 4'd4, 8'h00);  rd_chk("R1 hour_al", 4'd5, 8'hFF);
        rd_chk("R1 dow", 4'd6, 8'h01);   rd_chk("R1 date", 4'd7, 8'h01);
        rd_chk("R1 month", 4'd8, 8'h01); rd_chk("R1 year", 4'd9, 8'h00);
        rd_chk("R1 ctrl", 4'd10, 8'h04); rd_chk("R1 stat", 4'd11, 8'h00);
        rd_chk("R1 unmapped", 4'd14, 8'h00);

        // R3 R4: hour sweep over both encodings and both hour forms
        for (int mode = 0; mode < 4; mode++) begin
            bit bin = mode[0];
            bit h24 = mode[1];
            for (int h = 0; h < 24; h++) begin
                load(bin, h24, 59, 59, h, 3, 10, 5, 21);
                tick1();
                rd_chk("R3 hour step", 4'd4, enc_hr((h + 1) % 24, bin, h24));
                rd_chk("R2 min wrap", 4'd2, enc(0, bin));
                rd_chk("R4 dow at midnight only", 4'd6, enc(h == 23 ? 4 : 3, bin));
            end
        end

        // R5 R4: every month end over every year (BCD) and eight years (binary)
        for (int pass = 0; pass < 2; pass++) begin
            bit bin = pass[0];
            int ylim = bin ? 8 : 100;
            for (int y = 0; y < ylim; y++) begin
                for (int mo = 1; mo <= 12; mo++) begin
                    int dw = (mo % 7) + 1;
                    load(bin, 1'b1, 59, 59, 23, dw, mlen(mo, y), mo, y);
                    tick1();
                    rd_chk("R5 date wrap", 4'd7, enc(1, bin));
                    rd_chk("R5 month step", 4'd8, enc(mo == 12 ? 1 : mo + 1, bin));
                    rd_chk("R5 year", 4'd9, enc(mo == 12 ? (y + 1) % 100 : y, bin));
                    rd_chk("R4 dow wrap", 4'd6, enc(dw == 7 ? 1 : dw + 1, bin));
                end
            end
        end
        // R5 day before month end does not wrap
        for (int y = 0; y < 4; y++) begin
            for (int mo = 1; mo <= 12; mo++) begin
                load(1'b0, 1'b1, 59, 59, 23, 2, mlen(mo, y) - 1, mo, y);
                tick1();
                rd_chk("R5 last day", 4'd7, enc(mlen(mo, y), 1'b0));
                rd_chk("R5 month held", 4'd8, enc(mo, 1'b0));
            end
        end

        // R8 encoding of counting
        load(1'b0, 1'b1, 9, 0, 0, 1, 1, 1, 0);
        tick1();
        rd_chk("R8 bcd sec", 4'd0, 8'h10);
        load(1'b1, 1'b1, 9, 0, 0, 1, 1, 1, 0);
        tick1();
        rd_chk("R8 bin sec", 4'd0, 8'h0A);

        // R2 long run in binary across midnight and year end
        load(1'b1, 1'b1, 0, 0, 23, 7, 31, 12, 99);
        for (int t = 1; t <= 3661; t++) begin
            tick1();
            rd_chk("R2 sec run", 4'd0, 8'(t % 60));
        end
        rd_chk("R2 min run", 4'd2, 8'd1);
        rd_chk("R2 hour run", 4'd4, 8'd0);
        rd_chk("R4 dow run", 4'd6, 8'd1);
        rd_chk("R5 date run", 4'd7, 8'd1);
        rd_chk("R5 month run", 4'd8, 8'd1);
        rd_chk("R5 year run", 4'd9, 8'd0);
        repeat (5) @(negedge clk);
        rd_chk("R2 idle hold", 4'd0, 8'd1);

        // R11 read latency
        load(1'b0, 1'b1, 30, 20, 10, 1, 1, 1, 0);
        @(negedge clk); tick = 1'b1; addr = 4'd0;
        @(negedge clk); tick = 1'b0; #1 chk("R11 old value", rdata, 8'h30);
        @(negedge clk); #1 chk("R11 new value", rdata, 8'h31);

        // R6 hold bit
        load(1'b0, 1'b1, 3, 2, 1, 1, 1, 1, 0);
        ctrl_wr(1'b1, 1'b0, 1'b1);
        tick1(); tick1();
        rd_chk("R6 tick dropped", 4'd0, 8'h03);
        wr(4'd0, 8'h45);
        rd_chk("R6 write loads", 4'd0, 8'h45);
        ctrl_wr(1'b0, 1'b0, 1'b1);
        tick1();
        rd_chk("R6 resume", 4'd0, 8'h46);

        // R7 writes ignored without hold
        wr(4'd0, 8'h12);
        rd_chk("R7 sec unchanged", 4'd0, 8'h46);
        wr(4'd9, 8'h77);
        rd_chk("R7 year unchanged", 4'd9, 8'h00);
        wr(4'd1, 8'h33);
        rd_chk("R7 alarm writable", 4'd1, 8'h33);

        // R8 no conversion on mode change
        ctrl_wr(1'b0, 1'b1, 1'b1);
        rd_chk("R8 no convert", 4'd0, 8'h46);
        rd_chk("R8 ctrl", 4'd10, 8'h06);

        // R9 R10 alarm
        load(1'b0, 1'b1, 55, 34, 12, 1, 1, 1, 0);
        wr(4'd1, 8'h56); wr(4'd3, 8'h34); wr(4'd5, 8'h12);
        rd(4'd11, d);
        rd_chk("R9 no flag before", 4'd11, 8'h00);
        tick1();
        rd_chk("R9 flag set", 4'd11, 8'h01);
        rd_chk("R10 flag cleared", 4'd11, 8'h00);
        tick1();
        rd_chk("R9 no match", 4'd11, 8'h00);
        // R9 12-hour PM alarm, binary
        load(1'b1, 1'b0, 59, 59, 12, 1, 1, 1, 0);
        wr(4'd1, 8'h00); wr(4'd3, 8'h00); wr(4'd5, 8'h81);
        tick1();
        rd_chk("R9 pm alarm", 4'd11, 8'h01);
        rd_chk("R3 pm hour", 4'd4, 8'h81);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule